// File: doc/BRIEF.md
# Indirect-Indexed Controller Register Port

This block is the host-facing register access unit of a bus interface controller. The host sees only two byte locations, selected by `host_sel`. Location 0 returns an auxiliary status byte when read. When written, it stores a register index. Location 1 reads or writes whichever internal register the index points at. After every value access that takes effect, the index steps to the next register. This lets multibyte fields such as the 24-bit transfer count or a run of command descriptor bytes be streamed after a single index write. The data register is the exception: the index stays on it, so repeated transfers use the same location.

Behind the port is a bank of 26 byte registers. Index 23 holds status, index 24 the command and index 25 data. Indices 18 to 20 hold the transfer count, most significant byte first, and the descriptor bytes start at index 3. The bus protocol engine is not part of this block. It is modelled by busy and command-in-progress levels, plus a done pulse that carries a status code. While the engine is busy, access is restricted and blocked accesses do nothing. A command written at the wrong moment is dropped and flagged. Completion raises an interrupt, and reading the status register acknowledges it.

Top module: `ctrl_regport`

## Requirements
- R1: A read with `host_sel`=0 returns the auxiliary byte {bit7 interrupt pending, bit6 last command ignored, bit5 busy, bit4 command in progress, bits3:2 zero, bit1 parity error, bit0 data buffer ready}, and it leaves the index unchanged.
- R2: A write with `host_sel`=0 loads `host_wdata[4:0]` as the index, even while busy. A value access (`host_sel`=1) then reads or writes the register at that index.
- R3: A value access that takes effect advances the index by one, wrapping from 31 to 0. At index 25 (data) the index does not move.
- R4: `xfer_count_o` is {reg18, reg19, reg20}. Writing index 18 followed by three values loads the high, middle and low bytes.
- R5: Indices 0 to 22 are read/write storage; descriptor bytes occupy 3 to 14 and can be streamed. Indices 26 to 31 read 0x00 and ignore writes, but they still advance the index.
- R6: While busy or command-in-progress is set, a value access at any index other than 24 or 25 is blocked. It reads 0x00, writes nothing and does not advance the index.
- R7: While command-in-progress is set, the command register is also blocked. A command write is discarded and sets last-command-ignored, and the index stays put.
- R8: An accepted command write stores the byte at index 24 and clears last-command-ignored. One cycle later `cmd_fire_o` pulses, with `cmd_sbt_o` set to bit 7 and `cmd_code_o` set to bits 6:0.
- R9: An `eng_done` pulse loads `eng_status` into index 23 and sets interrupt pending (`irq_o`). It wins over a simultaneous acknowledge.
- R10: A permitted value read of index 23 clears interrupt pending on the next edge. Host writes to index 23 are ignored.
- R11: A synchronous `rst` clears all registers, the index, interrupt pending and last-command-ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | 0 = aux/index location, 1 = value location |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| eng_busy | input | 1 | Engine busy level |
| eng_cip | input | 1 | Engine command-in-progress level |
| eng_done | input | 1 | Command completion pulse |
| eng_status | input | 8 | Status code loaded on completion |
| eng_perr | input | 1 | Parity error flag shown in aux byte |
| eng_dbr | input | 1 | Data buffer ready flag shown in aux byte |
| irq_o | output | 1 | Interrupt pending |
| cmd_fire_o | output | 1 | One-cycle pulse after an accepted command |
| cmd_sbt_o | output | 1 | Single-byte-transfer qualifier of stored command |
| cmd_code_o | output | 7 | Command code of stored command |
| xfer_count_o | output | 24 | Assembled transfer count |

## Verification
The hardest case to reach from the ports is the interaction between the gating and the auto-increment. A command dropped under command-in-progress must leave both the index and the stored command unchanged. A blocked access must not move the index, so the next unblocked read shows where the index was left. The stimulus first parks the index on a storage register and raises busy or command-in-progress. It then attempts reads, writes and command writes, lowers the levels, and reads again to expose the index. A long run with random engine levels and completion pulses also exercises completion and acknowledge landing in the same cycle.

// File: rtl/regport_pkg.sv
package regport_pkg;
   localparam int unsigned RP_DW      = 8;
   localparam int unsigned RP_NREG    = 26;
   localparam int unsigned RP_TC_IDX  = 18;
   localparam int unsigned RP_TC_BYTES = 3;
   localparam int unsigned RP_STATUS  = 23;
   localparam int unsigned RP_CMD     = 24;
   localparam int unsigned RP_DATA    = 25;

   // auxiliary status byte, bit 7 first
   typedef struct packed {
      logic       int_pend;
      logic       lci;
      logic       busy;
      logic       cip;
      logic [1:0] zero;
      logic       perr;
      logic       dbr;
   } aux_t;
endpackage

// File: rtl/rp_access_gate.sv
module rp_access_gate #(
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned NREG     = 26,
   parameter int unsigned CMD_IDX  = 24,
   parameter int unsigned DATA_IDX = 25
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             busy,
   input  logic             cip,
   output logic             allow,
   output logic             cmd_locked,
   output logic             present
);
   localparam logic [IDX_W-1:0] L_CMD  = IDX_W'(CMD_IDX);
   localparam logic [IDX_W-1:0] L_DATA = IDX_W'(DATA_IDX);

   logic at_cmd, at_data;

   always_comb begin
      at_cmd     = (idx == L_CMD);
      at_data    = (idx == L_DATA);
      present    = (32'(idx) < NREG);
      allow      = at_data || (at_cmd && !cip) || (!busy && !cip);
      cmd_locked = at_cmd && cip;
   end
endmodule

// File: rtl/rp_index_ctl.sv
module rp_index_ctl #(
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned DATA_IDX = 25
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] L_DATA = IDX_W'(DATA_IDX);

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (load)
         idx <= load_val;
      else if (step && idx != L_DATA)
         idx <= idx + 1'b1;
   end
endmodule

// File: rtl/rp_reg_bank.sv
module rp_reg_bank #(
   parameter int unsigned DW         = 8,
   parameter int unsigned NREG       = 26,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned STATUS_IDX = 23
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DW-1:0]     wr_data,
   input  logic              st_load,
   input  logic [DW-1:0]     st_data,
   output logic [NREG*DW-1:0] regs_flat
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] r;
      if (g == STATUS_IDX) begin : g_status
         always_ff @(posedge clk) begin
            if (rst)          r <= '0;
            else if (st_load) r <= st_data;
         end
      end else begin : g_rw
         always_ff @(posedge clk) begin
            if (rst)                                     r <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))       r <= wr_data;
         end
      end
      assign regs_flat[g*DW +: DW] = r;
   end
endmodule

// File: rtl/ctrl_regport.sv
module ctrl_regport
   import regport_pkg::*;
#(
   parameter int unsigned DW         = RP_DW,
   parameter int unsigned NREG       = RP_NREG,
   parameter int unsigned TC_IDX     = RP_TC_IDX,
   parameter int unsigned TC_BYTES   = RP_TC_BYTES,
   parameter int unsigned STATUS_IDX = RP_STATUS,
   parameter int unsigned CMD_IDX    = RP_CMD,
   parameter int unsigned DATA_IDX   = RP_DATA
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   host_sel,
   input  logic                   host_wr,
   input  logic                   host_rd,
   input  logic [DW-1:0]          host_wdata,
   output logic [DW-1:0]          host_rdata,
   input  logic                   eng_busy,
   input  logic                   eng_cip,
   input  logic                   eng_done,
   input  logic [DW-1:0]          eng_status,
   input  logic                   eng_perr,
   input  logic                   eng_dbr,
   output logic                   irq_o,
   output logic                   cmd_fire_o,
   output logic                   cmd_sbt_o,
   output logic [DW-2:0]          cmd_code_o,
   output logic [TC_BYTES*DW-1:0] xfer_count_o
);
   localparam int unsigned IDX_W = $clog2(NREG);
   localparam logic [IDX_W-1:0] L_STATUS = IDX_W'(STATUS_IDX);
   localparam logic [IDX_W-1:0] L_CMD    = IDX_W'(CMD_IDX);

   // elaboration-time parameter checks
   if (DW != 8) begin : g_bad_dw
      $error("ctrl_regport: DW must be 8 to match the aux byte");
   end
   if (NREG != DATA_IDX + 1 || CMD_IDX != STATUS_IDX + 1 || DATA_IDX != CMD_IDX + 1) begin : g_bad_map
      $error("ctrl_regport: status, command and data must close the bank");
   end
   if (TC_IDX + TC_BYTES > STATUS_IDX) begin : g_bad_tc
      $error("ctrl_regport: transfer count overlaps the status register");
   end

   logic [IDX_W-1:0]   idx_q;
   logic               allow, cmd_locked, present;
   logic [NREG*DW-1:0] regs_flat;
   logic               int_q, lci_q, fire_q;
   logic               val_acc, acc_ok, bank_wr, cmd_take, cmd_drop, st_ack;
   logic [DW-1:0]      cur_reg, cmd_reg;
   aux_t               aux;

   rp_access_gate #(
      .IDX_W(IDX_W), .NREG(NREG), .CMD_IDX(CMD_IDX), .DATA_IDX(DATA_IDX)
   ) u_gate (
      .idx(idx_q), .busy(eng_busy), .cip(eng_cip),
      .allow(allow), .cmd_locked(cmd_locked), .present(present)
   );

   always_comb begin
      val_acc  = host_sel && (host_wr || host_rd);
      acc_ok   = val_acc && allow;
      bank_wr  = host_sel && host_wr && allow && present;
      cmd_take = host_sel && host_wr && allow && (idx_q == L_CMD);
      cmd_drop = host_sel && host_wr && cmd_locked;
      st_ack   = host_sel && host_rd && allow && (idx_q == L_STATUS);
   end

   rp_index_ctl #(.IDX_W(IDX_W), .DATA_IDX(DATA_IDX)) u_index (
      .clk(clk), .rst(rst),
      .load(!host_sel && host_wr), .load_val(host_wdata[IDX_W-1:0]),
      .step(acc_ok), .idx(idx_q)
   );

   rp_reg_bank #(
      .DW(DW), .NREG(NREG), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX)
   ) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(bank_wr), .wr_idx(idx_q), .wr_data(host_wdata),
      .st_load(eng_done), .st_data(eng_status),
      .regs_flat(regs_flat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         int_q  <= 1'b0;
         lci_q  <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= cmd_take;
         if (eng_done)    int_q <= 1'b1;
         else if (st_ack) int_q <= 1'b0;
         if (cmd_drop)      lci_q <= 1'b1;
         else if (cmd_take) lci_q <= 1'b0;
      end
   end

   always_comb begin
      aux.int_pend = int_q;
      aux.lci      = lci_q;
      aux.busy     = eng_busy;
      aux.cip      = eng_cip;
      aux.zero     = 2'b00;
      aux.perr     = eng_perr;
      aux.dbr      = eng_dbr;
      cur_reg      = present ? regs_flat[int'(idx_q)*DW +: DW] : '0;
      cmd_reg      = regs_flat[CMD_IDX*DW +: DW];
      if (!host_sel)   host_rdata = aux;
      else if (allow)  host_rdata = cur_reg;
      else             host_rdata = '0;
   end

   for (genvar b = 0; b < TC_BYTES; b++) begin : g_tc
      assign xfer_count_o[(TC_BYTES-1-b)*DW +: DW] = regs_flat[(TC_IDX+b)*DW +: DW];
   end

   assign irq_o      = int_q;
   assign cmd_fire_o = fire_q;
   assign cmd_sbt_o  = cmd_reg[DW-1];
   assign cmd_code_o = cmd_reg[DW-2:0];
endmodule

// File: rtl/ctrl_regport_chk.sv
module ctrl_regport_chk #(
   parameter int unsigned DW         = 8,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned STATUS_IDX = 23,
   parameter int unsigned DATA_IDX   = 25
) (
   input logic             clk,
   input logic             rst,
   input logic             host_sel,
   input logic             host_wr,
   input logic             host_rd,
   input logic [DW-1:0]    host_rdata,
   input logic             eng_busy,
   input logic             eng_cip,
   input logic             eng_done,
   input logic             irq_o,
   input logic             cmd_fire_o,
   input logic             lci,
   input logic [IDX_W-1:0] idx
);
   AST_FIRE_CLEARS_LCI: assert property (@(posedge clk) disable iff (rst)
      cmd_fire_o |-> !lci); // R8
   AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
      eng_done |=> irq_o); // R9
   AST_LCI_CAUSE: assert property (@(posedge clk) disable iff (rst)
      ($rose(lci) && !$past(rst)) |-> $past(host_sel && host_wr && eng_cip)); // R7
   AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
      ($fell(irq_o) && !$past(rst)) |-> $past(host_sel && host_rd)); // R10
   AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (host_sel && (eng_busy || eng_cip) && 32'(idx) < STATUS_IDX) |-> host_rdata == '0); // R6
   AST_DATA_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (host_sel && (host_wr || host_rd) && idx == IDX_W'(DATA_IDX)) |=> idx == IDX_W'(DATA_IDX)); // R3
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> (!irq_o && !cmd_fire_o && !lci && idx == '0)); // R11
endmodule

bind ctrl_regport ctrl_regport_chk #(
   .DW(DW), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .DATA_IDX(DATA_IDX)
) u_chk (
   .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
   .host_rdata(host_rdata), .eng_busy(eng_busy), .eng_cip(eng_cip), .eng_done(eng_done),
   .irq_o(irq_o), .cmd_fire_o(cmd_fire_o), .lci(lci_q), .idx(idx_q)
);

// File: tb/ctrl_regport_tb.sv
module ctrl_regport_tb;
   localparam int CLK_NS = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic eng_busy = 1'b0, eng_cip = 1'b0, eng_done = 1'b0, eng_perr = 1'b0, eng_dbr = 1'b0;
   logic [7:0] eng_status = '0;
   logic irq_o, cmd_fire_o, cmd_sbt_o;
   logic [6:0] cmd_code_o;
   logic [23:0] xfer_count_o;

   always #(CLK_NS/2) clk = ~clk;

   ctrl_regport u_dut (
      .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_busy(eng_busy),
      .eng_cip(eng_cip), .eng_done(eng_done), .eng_status(eng_status),
      .eng_perr(eng_perr), .eng_dbr(eng_dbr), .irq_o(irq_o), .cmd_fire_o(cmd_fire_o),
      .cmd_sbt_o(cmd_sbt_o), .cmd_code_o(cmd_code_o), .xfer_count_o(xfer_count_o)
   );

   // behavioural reference state
   int m_mem[32];
   int m_idx, m_int, m_lci, m_fire;
   int n_chk = 0, n_bad = 0;
   bit done_flag = 0;
   logic [7:0] seen;

   task automatic expect_eq(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit m_allow();
      return (m_idx == 25) || (m_idx == 24 && !eng_cip) || (!eng_busy && !eng_cip);
   endfunction

   task automatic model_clear();
      foreach (m_mem[i]) m_mem[i] = 0;
      m_idx = 0; m_int = 0; m_lci = 0; m_fire = 0;
   endtask

   // one clock: drive at negedge, compare before posedge, update model at posedge
   task automatic cyc(input bit sel, input bit wr, input bit rd, input int wd);
      int exp_rd, aux, oi;
      bit al, clr, fire_n;
      host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = 8'(wd);
      #2;
      al  = m_allow();
      aux = (m_int << 7) | (m_lci << 6) | (int'(eng_busy) << 5) | (int'(eng_cip) << 4)
            | (int'(eng_perr) << 1) | int'(eng_dbr);
      if (!sel) exp_rd = aux;
      else exp_rd = (al && m_idx < 26) ? m_mem[m_idx] : 0;
      seen = host_rdata;
      if (!rst) begin
         expect_eq(host_rdata, exp_rd, sel ? "R2 value read" : "R1 aux read");
         expect_eq(irq_o, m_int, "R9 irq");
         expect_eq(cmd_fire_o, m_fire, "R8 fire");
         expect_eq({cmd_sbt_o, cmd_code_o}, m_mem[24], "R8 cmd fields");
         expect_eq(xfer_count_o, (m_mem[18] << 16) | (m_mem[19] << 8) | m_mem[20], "R4 count");
      end
      @(posedge clk);
      if (rst) model_clear();
      else begin
         oi = m_idx; clr = 0; fire_n = 0;
         if (!sel && wr) m_idx = wd & 31;
         else if (sel && (wr || rd) && al) begin
            if (wr && oi < 26 && oi != 23) m_mem[oi] = wd & 255;
            if (wr && oi == 24) begin m_lci = 0; fire_n = 1; end
            if (rd && oi == 23) clr = 1;
            if (oi != 25) m_idx = (oi + 1) % 32;
         end
         if (sel && wr && oi == 24 && eng_cip) m_lci = 1;
         if (eng_done) begin m_int = 1; m_mem[23] = int'(eng_status); end
         else if (clr) m_int = 0;
         m_fire = fire_n;
      end
      @(negedge clk);
   endtask

   task automatic wr_idx(input int i);  cyc(0, 1, 0, i); endtask
   task automatic wr_val(input int v);  cyc(1, 1, 0, v); endtask
   task automatic rd_val();             cyc(1, 0, 1, 0); endtask
   task automatic rd_aux();             cyc(0, 0, 1, 0); endtask

   initial begin
      model_clear();
      @(negedge clk);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      rst = 1'b0;
      // R11 reset state
      rd_aux();  expect_eq(seen, 0, "R11 aux after reset");
      expect_eq(xfer_count_o, 0, "R11 count after reset");

      // R4 transfer count streaming
      wr_idx(18); wr_val(8'hA1); wr_val(8'hB2); wr_val(8'hC3);
      expect_eq(xfer_count_o, 24'hA1B2C3, "R4 count loaded msb first");
      // R3 readback through auto-increment
      wr_idx(18); rd_val(); expect_eq(seen, 8'hA1, "R3 step 18");
      rd_val(); expect_eq(seen, 8'hB2, "R3 step 19");
      rd_val(); expect_eq(seen, 8'hC3, "R3 step 20");
      // R1 aux read does not move index (next value read is index 21)
      wr_val(8'h5A); wr_idx(21); rd_aux(); rd_val(); expect_eq(seen, 8'h5A, "R1 index held");

      // R5 descriptor stream at 3..14
      wr_idx(3);
      for (int k = 0; k < 12; k++) wr_val(8'h30 + k);
      wr_idx(3);  rd_val(); expect_eq(seen, 8'h30, "R5 first descriptor");
      wr_idx(14); rd_val(); expect_eq(seen, 8'h3B, "R5 last descriptor");
      // R5 unimplemented indices, wrap 31 -> 0
      wr_idx(0); wr_val(8'h66);
      wr_idx(30); wr_val(8'h55); rd_val(); expect_eq(seen, 0, "R5 unimplemented reads zero");
      rd_val(); expect_eq(seen, 8'h66, "R5 wrap to index 0");

      // R3 data register holds index
      wr_idx(25); wr_val(8'h11); wr_val(8'h22);
      rd_val(); expect_eq(seen, 8'h22, "R3 data repeat");
      rd_val(); expect_eq(seen, 8'h22, "R3 data index held");

      // R6 busy gating
      wr_idx(5); eng_busy = 1'b1;
      wr_val(8'h77); rd_val(); expect_eq(seen, 0, "R6 blocked read zero");
      eng_busy = 1'b0;
      rd_val(); expect_eq(seen, 8'h32, "R6 blocked write dropped, index held");
      eng_busy = 1'b1;
      wr_idx(25); rd_val(); expect_eq(seen, 8'h22, "R6 data reachable while busy");

      // R7 command dropped under cip
      eng_cip = 1'b1;
      wr_idx(24); wr_val(8'h05);
      rd_aux(); expect_eq(seen, 8'h70, "R7 lci set");
      expect_eq(cmd_code_o, 0, "R7 command not stored");
      eng_cip = 1'b0;
      // R8 accepted command while busy
      wr_val(8'h88);
      expect_eq(cmd_fire_o, 1, "R8 fire pulse");
      expect_eq(cmd_sbt_o, 1, "R8 sbt"); expect_eq(cmd_code_o, 8, "R8 code");
      rd_aux(); expect_eq(seen, 8'h20, "R8 lci cleared");
      expect_eq(cmd_fire_o, 0, "R8 single pulse");
      eng_busy = 1'b0;

      // R9 / R10 completion and acknowledge
      eng_status = 8'h42; eng_done = 1'b1; cyc(0, 0, 0, 0); eng_done = 1'b0;
      expect_eq(irq_o, 1, "R9 irq set");
      wr_idx(23); wr_val(8'h99);
      wr_idx(23); rd_val(); expect_eq(seen, 8'h42, "R10 status kept after host write");
      expect_eq(irq_o, 0, "R10 irq acknowledged");
      eng_status = 8'h16; eng_done = 1'b1; cyc(0, 0, 0, 0);
      wr_idx(23); cyc(1, 0, 1, 0); eng_done = 1'b0;
      expect_eq(irq_o, 1, "R9 done wins over ack");

      // random traffic with engine activity
      for (int k = 0; k < 3000; k++) begin
         int r = $urandom;
         eng_busy   = (r[3:0] == 0);
         eng_cip    = (r[5:4] == 0) && eng_busy;
         eng_done   = (r[9:6] == 0);
         eng_status = 8'($urandom);
         eng_perr   = r[10];
         eng_dbr    = r[11];
         case (r[14:12])
            0: cyc(0, 1, 0, (r[15] ? 16 + $urandom % 10 : $urandom % 32));
            1, 2: cyc(1, 1, 0, $urandom % 256);
            3, 4: cyc(1, 0, 1, 0);
            5: cyc(0, 0, 1, 0);
            default: cyc(0, 0, 0, 0);
         endcase
      end
      eng_busy = 0; eng_cip = 0; eng_done = 0;

      // R11 reset mid-run
      rst = 1'b1; cyc(0, 0, 0, 0); rst = 1'b0;
      expect_eq(irq_o, 0, "R11 irq cleared");
      expect_eq(xfer_count_o, 0, "R11 count cleared");
      rd_val(); expect_eq(seen, 0, "R11 index 0 reg cleared");

      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule